// File: doc/BRIEF.md
# Sticky Fault Flag and Alert Controller

This block watches two digitized monitor readings inside a power controller: an average-current code and a thermistor voltage code. The current reading trips when it rises above a selectable limit. The thermistor reading has two limits, a warning limit and a lower fault limit, and each trips when the reading falls below it. A trip needs two consecutive samples in the trip region, and detection counts only while the detection enable is high. The enable goes high when soft-start begins.

Every trip sets a sticky flag in an 8-bit status vector. The flag stays set after the condition goes away, until a write-one-to-clear, a clear-all strobe or a reset. An active-low alert stays asserted while any flag is set. The current fault and the thermistor fault also stop switching unless their mask bit is set. The warning never stops switching. Two shutdown responses are available. Hiccup waits until the condition has been absent for a fixed number of samples and then requests a new soft-start. Latch-off holds switching off until reset.

Top module: `fault_alert_ctrl`

## Requirements
- R1: The current flag (status bit 4) trips when `imon_code` is strictly greater than the current limit. The limit is `OC_BASE + OC_STEP*sel`, where sel is config register (address 2) bits [3:1]. sel resets to 4, which gives a limit of 800 by default.
- R2: The warning flag (bit 1) trips when `ntc_code` is strictly below the warning limit (address 3, reset 180). The over-temperature flag (bit 3) trips when `ntc_code` is strictly below the fault limit (address 4, reset 120).
- R3: A flag sets at the second consecutive clock edge that samples its trip condition. A condition seen at a single edge sets nothing.
- R4: Samples taken while `det_en` is low neither trip nor count toward the two-sample rule.
- R5: A set flag stays at 1 after its condition clears, until it is cleared.
- R6: A write to address 0 clears each status bit written with 1. `clr_all` clears every bit. A trip in the same cycle as a clear wins, and the bit stays 1.
- R7: `alert_n` is 0 while any status bit is 1, and 1 when all status bits are 0.
- R8: An unmasked trip of bit 4 or bit 3 drives `pwm_dis` high from that same edge. The mask register (address 1) uses the same bit positions; a 1 there keeps switching running, but the flag still sets.
- R9: A warning trip never raises `pwm_dis`.
- R10: In hiccup mode (config bit 0 = 0), once the unmasked protected conditions have been absent for `HIC_DLY` consecutive edges, `pwm_dis` falls and `ss_req` pulses high for one cycle, both at the same edge. The flags stay set.
- R11: In latch-off mode (config bit 0 = 1), `pwm_dis` stays high until `rst`, whatever happens to the condition, the flags or the clears.
- R12: Reset leaves the status at 0, `alert_n` at 1, `pwm_dis` at 0 and `ss_req` at 0, and restores the register defaults: mask 0, hiccup mode, sel 4, and limits 180 and 120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also stands for an enable or power-on cycle |
| det_en | input | 1 | Detection enable, high from the start of soft-start |
| imon_code | input | ADC_W | Average-current monitor code |
| ntc_code | input | ADC_W | Thermistor voltage code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 status, 1 mask, 2 config, 3 warning limit, 4 fault limit) |
| wr_data | input | ADC_W | Register write data |
| clr_all | input | 1 | Clear-all-flags strobe |
| status_flags | output | 8 | Sticky status vector |
| alert_n | output | 1 | Active-low alert |
| pwm_dis | output | 1 | Switching stop request |
| ss_req | output | 1 | One-cycle soft-start request on hiccup restart |

## Verification
The bench keeps the default code width, limit base, step and reset limits, so the boundary codes 800/801, 180/179 and 120/119 are tested exactly as they are set after reset. It lowers `HIC_DLY` to 5, which makes the whole hiccup wait short enough to count edge by edge. That lets the bench check the edge just before the restart as well as the restart edge. Reprogramming sel to 0 and moving both thermistor limits checks that the comparisons follow the registers and not fixed constants.

// File: rtl/fault_alert_pkg.sv
`timescale 1ns/1ps
package fault_alert_pkg;

    localparam int STAT_W      = 8;
    localparam int BIT_OT_WARN = 1;
    localparam int BIT_OT_FLT  = 3;
    localparam int BIT_OC_AVG  = 4;

    // Bits whose trip may stop switching
    localparam logic [STAT_W-1:0] PROT_BITS = 8'b0001_1000;

    typedef enum logic [2:0] {
        ADDR_STATUS   = 3'd0,
        ADDR_MASK     = 3'd1,
        ADDR_CFG      = 3'd2,
        ADDR_WARN_LIM = 3'd3,
        ADDR_FLT_LIM  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        RSP_RUN,
        RSP_HICCUP,
        RSP_LATCHED
    } rsp_state_e;

    typedef enum logic {
        TRIP_ABOVE,
        TRIP_BELOW
    } trip_dir_e;

    typedef struct packed {
        logic [2:0] oc_sel;
        logic       latch_off;
    } cfg_t;

    function automatic int unsigned oc_limit(input int unsigned base,
                                             input int unsigned step,
                                             input logic [2:0]  sel);
        return base + step * int'(sel);
    endfunction

endpackage

// File: rtl/fa_trip_filter.sv
`timescale 1ns/1ps
module fa_trip_filter
    import fault_alert_pkg::*;
#(
    parameter int        W   = 10,
    parameter trip_dir_e DIR = TRIP_ABOVE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         det_en,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] limit,
    output logic         raw_o,
    output logic         trip_o
);

    logic cmp;
    logic prev_q;

    generate
        if (DIR == TRIP_ABOVE) begin : g_above
            assign cmp = sample > limit;
        end else begin : g_below
            assign cmp = sample < limit;
        end
    endgenerate

    assign raw_o = det_en & cmp;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= raw_o;
    end

    assign trip_o = prev_q & raw_o;

    AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (rst)
        !$past(det_en) |-> !trip_o); // R4

endmodule

// File: rtl/fa_cfg_regs.sv
`timescale 1ns/1ps
module fa_cfg_regs
    import fault_alert_pkg::*;
#(
    parameter int          W          = 10,
    parameter int unsigned OC_BASE    = 560,
    parameter int unsigned OC_STEP    = 60,
    parameter logic [2:0]  OC_SEL_RST = 3'd4,
    parameter int unsigned WARN_RST   = 180,
    parameter int unsigned FLT_RST    = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [STAT_W-1:0] mask_q,
    output logic              latch_off,
    output logic [W-1:0]      oc_lim,
    output logic [W-1:0]      warn_lim,
    output logic [W-1:0]      flt_lim
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            cfg_q    <= '{oc_sel: OC_SEL_RST, latch_off: 1'b0};
            warn_lim <= W'(WARN_RST);
            flt_lim  <= W'(FLT_RST);
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_MASK:     mask_q   <= wr_data[STAT_W-1:0];
                ADDR_CFG:      cfg_q    <= cfg_t'(wr_data[3:0]);
                ADDR_WARN_LIM: warn_lim <= wr_data;
                ADDR_FLT_LIM:  flt_lim  <= wr_data;
                default: ;
            endcase
        end
    end

    assign latch_off = cfg_q.latch_off;
    assign oc_lim    = W'(oc_limit(OC_BASE, OC_STEP, cfg_q.oc_sel));

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_q)); // R8

endmodule

// File: rtl/fa_status_reg.sv
`timescale 1ns/1ps
module fa_status_reg
    import fault_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] trip_vec,
    input  logic [STAT_W-1:0] w1c_vec,
    input  logic              clr_all,
    output logic [STAT_W-1:0] status_q
);

    logic [STAT_W-1:0] clr_vec;

    assign clr_vec = w1c_vec | {STAT_W{clr_all}};

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_vec) | trip_vec;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(status_q) & ~$past(clr_vec) & ~status_q) == '0); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (trip_vec != '0) |=> ((status_q & $past(trip_vec)) == $past(trip_vec))); // R6

endmodule

// File: rtl/fa_response_fsm.sv
`timescale 1ns/1ps
module fa_response_fsm
    import fault_alert_pkg::*;
#(
    parameter int HIC_DLY = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic prot_trip,
    input  logic prot_cond,
    input  logic latch_off,
    output logic pwm_dis,
    output logic ss_req
);

    localparam int CNT_W = (HIC_DLY > 1) ? $clog2(HIC_DLY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HIC_DLY - 1);

    rsp_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RSP_RUN;
            cnt_q   <= '0;
            ss_req  <= 1'b0;
        end else begin
            ss_req <= 1'b0;
            case (state_q)
                RSP_RUN: begin
                    if (prot_trip) begin
                        state_q <= latch_off ? RSP_LATCHED : RSP_HICCUP;
                        cnt_q   <= '0;
                    end
                end
                RSP_HICCUP: begin
                    if (prot_cond) begin
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_LAST) begin
                        state_q <= RSP_RUN;
                        cnt_q   <= '0;
                        ss_req  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RSP_LATCHED: ;
                default: state_q <= RSP_RUN;
            endcase
        end
    end

    assign pwm_dis = (state_q != RSP_RUN);

    AST_TRIP_STOPS: assert property (@(posedge clk) disable iff (rst)
        (prot_trip && state_q == RSP_RUN) |=> pwm_dis); // R8

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == RSP_LATCHED) |=> (state_q == RSP_LATCHED)); // R11

    AST_SS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ss_req |=> !ss_req); // R10

    AST_SS_ON_RESUME: assert property (@(posedge clk) disable iff (rst)
        ss_req |-> ($past(state_q) == RSP_HICCUP && !pwm_dis)); // R10

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST); // R10

endmodule

// File: rtl/fault_alert_ctrl.sv
`timescale 1ns/1ps
module fault_alert_ctrl
    import fault_alert_pkg::*;
#(
    parameter int          ADC_W      = 10,
    parameter int unsigned OC_BASE    = 560,
    parameter int unsigned OC_STEP    = 60,
    parameter logic [2:0]  OC_SEL_RST = 3'd4,
    parameter int unsigned WARN_RST   = 180,
    parameter int unsigned FLT_RST    = 120,
    parameter int          HIC_DLY    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_en,
    input  logic [ADC_W-1:0]  imon_code,
    input  logic [ADC_W-1:0]  ntc_code,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [ADC_W-1:0]  wr_data,
    input  logic              clr_all,
    output logic [STAT_W-1:0] status_flags,
    output logic              alert_n,
    output logic              pwm_dis,
    output logic              ss_req
);

    logic [STAT_W-1:0] mask_q;
    logic              latch_off;
    logic [ADC_W-1:0]  oc_lim, warn_lim, flt_lim;
    logic              oc_raw, oc_trip, warn_raw, warn_trip, flt_raw, flt_trip;
    logic [STAT_W-1:0] raw_vec, trip_vec, w1c_vec;
    logic              prot_trip, prot_cond;

    fa_cfg_regs #(
        .W(ADC_W), .OC_BASE(OC_BASE), .OC_STEP(OC_STEP),
        .OC_SEL_RST(OC_SEL_RST), .WARN_RST(WARN_RST), .FLT_RST(FLT_RST)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mask_q(mask_q), .latch_off(latch_off),
        .oc_lim(oc_lim), .warn_lim(warn_lim), .flt_lim(flt_lim)
    );

    fa_trip_filter #(.W(ADC_W), .DIR(TRIP_ABOVE)) u_oc (
        .clk(clk), .rst(rst), .det_en(det_en), .sample(imon_code), .limit(oc_lim),
        .raw_o(oc_raw), .trip_o(oc_trip)
    );

    fa_trip_filter #(.W(ADC_W), .DIR(TRIP_BELOW)) u_warn (
        .clk(clk), .rst(rst), .det_en(det_en), .sample(ntc_code), .limit(warn_lim),
        .raw_o(warn_raw), .trip_o(warn_trip)
    );

    fa_trip_filter #(.W(ADC_W), .DIR(TRIP_BELOW)) u_flt (
        .clk(clk), .rst(rst), .det_en(det_en), .sample(ntc_code), .limit(flt_lim),
        .raw_o(flt_raw), .trip_o(flt_trip)
    );

    always_comb begin
        raw_vec  = '0;
        trip_vec = '0;
        raw_vec[BIT_OC_AVG]   = oc_raw;
        raw_vec[BIT_OT_FLT]   = flt_raw;
        raw_vec[BIT_OT_WARN]  = warn_raw;
        trip_vec[BIT_OC_AVG]  = oc_trip;
        trip_vec[BIT_OT_FLT]  = flt_trip;
        trip_vec[BIT_OT_WARN] = warn_trip;
    end

    assign w1c_vec   = (wr_en && reg_addr_e'(wr_addr) == ADDR_STATUS) ?
                       wr_data[STAT_W-1:0] : '0;
    assign prot_trip = |(trip_vec & PROT_BITS & ~mask_q);
    assign prot_cond = |(raw_vec & PROT_BITS & ~mask_q);

    fa_status_reg u_status (
        .clk(clk), .rst(rst), .trip_vec(trip_vec), .w1c_vec(w1c_vec),
        .clr_all(clr_all), .status_q(status_flags)
    );

    fa_response_fsm #(.HIC_DLY(HIC_DLY)) u_rsp (
        .clk(clk), .rst(rst), .prot_trip(prot_trip), .prot_cond(prot_cond),
        .latch_off(latch_off), .pwm_dis(pwm_dis), .ss_req(ss_req)
    );

    assign alert_n = ~|status_flags;

    AST_WARN_NO_STOP: assert property (@(posedge clk) disable iff (rst)
        (!pwm_dis && !prot_trip) |=> !pwm_dis); // R9

    AST_FLAG_ON_TRIP: assert property (@(posedge clk) disable iff (rst)
        (oc_trip || flt_trip || warn_trip) |=> !alert_n); // R7

endmodule

// File: tb/tb_fault_alert_ctrl.sv
`timescale 1ns/1ps
module tb_fault_alert_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       det_en = 1'b0;
    logic [9:0] imon_code = '0;
    logic [9:0] ntc_code = 10'd500;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic       clr_all = 1'b0;
    logic [7:0] status_flags;
    logic       alert_n, pwm_dis, ss_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fault_alert_ctrl #(.HIC_DLY(5)) dut (
        .clk(clk), .rst(rst), .det_en(det_en), .imon_code(imon_code),
        .ntc_code(ntc_code), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_all(clr_all), .status_flags(status_flags), .alert_n(alert_n),
        .pwm_dis(pwm_dis), .ss_req(ss_req)
    );

    typedef struct packed {
        logic [9:0] imon;
        logic [9:0] ntc;
        logic       det;
        logic [3:0] edges;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{10'd801,  10'd500, 1'b1, 4'd2, 8'h10, 4'd1}, // R1 just above limit
        '{10'd800,  10'd500, 1'b1, 4'd3, 8'h00, 4'd1}, // R1 at limit
        '{10'd801,  10'd500, 1'b1, 4'd1, 8'h00, 4'd3}, // R3 single sample
        '{10'd900,  10'd500, 1'b0, 4'd3, 8'h00, 4'd4}, // R4 detection off
        '{10'd0,    10'd179, 1'b1, 4'd2, 8'h02, 4'd2}, // R2 warning
        '{10'd0,    10'd180, 1'b1, 4'd3, 8'h00, 4'd2}, // R2 at warn limit
        '{10'd0,    10'd119, 1'b1, 4'd2, 8'h0A, 4'd2}, // R2 fault and warning
        '{10'd0,    10'd120, 1'b1, 4'd2, 8'h02, 4'd2}, // R2 at fault limit
        '{10'd1000, 10'd50,  1'b1, 4'd2, 8'h1A, 4'd2}  // R2 all three
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [9:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic idle_clear();
        imon_code = '0; ntc_code = 10'd500; det_en = 1'b1;
        tick(1);
        clr_all = 1'b1;
        tick(1);
        clr_all = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        tick(2);
        rst = 1'b0;
        // R12 reset state
        chk("R12 status", status_flags, 8'h00);
        chk("R12 alert_n", alert_n, 1'b1);
        chk("R12 pwm_dis", pwm_dis, 1'b0);
        chk("R12 ss_req", ss_req, 1'b0);

        det_en = 1'b1;
        wr(3'd1, 10'h0FF);
        for (int i = 0; i < 9; i++) begin
            imon_code = VECS[i].imon;
            ntc_code  = VECS[i].ntc;
            det_en    = VECS[i].det;
            tick(int'(VECS[i].edges));
            chk($sformatf("R%0d vector %0d status", VECS[i].req, i), status_flags, VECS[i].exp);
            chk($sformatf("R7 vector %0d alert_n", i), alert_n, (VECS[i].exp == 8'h00));
            idle_clear();
        end

        // R5 sticky flag
        imon_code = 10'd801; tick(2);
        imon_code = '0; tick(5);
        chk("R5 held flag", status_flags, 8'h10);
        chk("R7 alert held", alert_n, 1'b0);

        // R6 write-one-to-clear selects bits
        wr(3'd0, 10'h002);
        chk("R6 other bit kept", status_flags, 8'h10);
        wr(3'd0, 10'h010);
        chk("R6 bit cleared", status_flags, 8'h00);
        chk("R7 alert released", alert_n, 1'b1);

        // R6 set wins over clear
        ntc_code = 10'd150; tick(2);
        wr(3'd0, 10'h002);
        chk("R6 set beats clear", status_flags, 8'h02);
        idle_clear();
        chk("R6 clear all", status_flags, 8'h00);

        // R9 warning never stops switching
        wr(3'd1, 10'h000);
        ntc_code = 10'd150; tick(3);
        chk("R9 pwm_dis on warning", pwm_dis, 1'b0);
        chk("R9 warning flag", status_flags, 8'h02);
        idle_clear();

        // R8 and R10 hiccup
        imon_code = 10'd801; tick(1);
        chk("R8 no stop after one sample", pwm_dis, 1'b0);
        tick(1);
        chk("R8 stop on trip", pwm_dis, 1'b1);
        tick(10);
        chk("R10 held while present", pwm_dis, 1'b1);
        imon_code = '0; tick(4);
        chk("R10 still off before delay", pwm_dis, 1'b1);
        chk("R10 no early request", ss_req, 1'b0);
        tick(1);
        chk("R10 resume", pwm_dis, 1'b0);
        chk("R10 soft-start pulse", ss_req, 1'b1);
        tick(1);
        chk("R10 pulse one cycle", ss_req, 1'b0);
        chk("R10 flag kept", status_flags, 8'h10);
        idle_clear();

        // R8 masked fault keeps switching
        wr(3'd1, 10'h010);
        imon_code = 10'd801; tick(3);
        chk("R8 masked flag sets", status_flags, 8'h10);
        chk("R8 masked no stop", pwm_dis, 1'b0);
        idle_clear();

        // R11 latch-off on thermistor fault
        wr(3'd2, 10'h009);
        wr(3'd1, 10'h000);
        ntc_code = 10'd100; tick(2);
        chk("R11 stop on fault", pwm_dis, 1'b1);
        chk("R2 fault flags", status_flags, 8'h0A);
        ntc_code = 10'd500; tick(20);
        clr_all = 1'b1; tick(1); clr_all = 1'b0;
        chk("R11 latched after clear", pwm_dis, 1'b1);
        chk("R11 no restart request", ss_req, 1'b0);
        chk("R6 cleared under latch", status_flags, 8'h00);
        rst = 1'b1; tick(1); rst = 1'b0;
        chk("R12 reset ends latch", pwm_dis, 1'b0);

        // R1 programmable limit selection
        wr(3'd1, 10'h0FF);
        wr(3'd2, 10'h000);
        imon_code = 10'd560; tick(3);
        chk("R1 sel0 at limit", status_flags, 8'h00);
        imon_code = 10'd561; tick(2);
        chk("R1 sel0 above limit", status_flags, 8'h10);
        idle_clear();

        // R2 programmable thermistor limits
        wr(3'd3, 10'd300);
        ntc_code = 10'd299; tick(2);
        chk("R2 new warn limit", status_flags, 8'h02);
        idle_clear();
        wr(3'd4, 10'd200);
        ntc_code = 10'd199; tick(2);
        chk("R2 new fault limit", status_flags, 8'h0A);
        idle_clear();

        done = 1'b1;
        finish_run();
    end

endmodule